// File: doc/BRIEF.md
# Datapath ALU with Compare and Shift

A purely combinational arithmetic-logic unit for the datapath of a small 16-bit processor. Each cycle it receives two register operands, an 8-bit immediate and a 4-bit function code, and it returns a 16-bit result and a zero flag. The zero flag is intended as the condition bit that the sequencing logic uses for branch decisions.

The unit covers bitwise logic, modular add and subtract, and two shifts driven by a signed amount: an arithmetic shift and a logical shift. These shifts act as multiply or divide by a power of two for signed and for unsigned values. It also provides signed and unsigned ordering compares, an equality compare that returns a 0/1 word, a pass-through move, and a move-high that loads the immediate into the upper byte. There is no state, so a new result is available in the same cycle that the inputs change. No valid/ready handshake is added, because the unit holds nothing and cannot apply back-pressure. The instruction decoder around it sets the timing.

Top module: `alu_datapath`

## Requirements
- R1: Codes 0, 1, 2 and 3 return A AND B, A OR B, A XOR B and NOT A (bitwise).
- R2: Code 4 returns A+B and code 5 returns A-B, both modulo 2^16.
- R3: For codes 6 and 7, the shift amount is B[4:0] read as two's complement (-16..15). A value n >= 0 shifts A left by n and fills the low bits with zeros, so the result is A*2^n modulo 2^16.
- R4: A negative amount -m shifts right by m. Code 6 (arithmetic) fills with the sign bit, which equals the floor of signed A divided by 2^m. Code 7 (logical) fills with zeros, which equals unsigned A divided by 2^m. With m=16, code 6 gives all copies of A[15] and code 7 gives 0.
- R5: Code 8 tests signed A<B and code 9 tests signed A<=B.
- R6: Code 11 tests unsigned A<B and code 12 tests unsigned A<=B.
- R7: Code 10 tests A==B.
- R8: Every compare (codes 8 to 12) returns 16'h0001 when true and 16'h0000 when false.
- R9: Code 13 returns A unchanged.
- R10: Code 14 returns {imm[7:0], A[7:0]}.
- R11: The zero flag is 1 exactly when the 16-bit result is all zeros.
- R12: Code 15 is unused and returns 16'h0000 with the zero flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Function code |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B (also supplies the shift amount) |
| imm8 | input | 8 | Immediate for move-high |
| result | output | 16 | Function result |
| zero_flag | output | 1 | Set when result is zero |

## Verification
The bound checker evaluates relations that must hold on every input change. It checks that add and subtract invert each other against the operands, that compares produce only 0 or 1, that equality agrees with the zero flag, that move and move-high keep the bytes they should, that a shift by -16 saturates, and that the unused code yields zero. Exact shift and ordering results across the sign boundary can only be shown by the bench's sweeps. The bench crosses corner operands over every function, runs every shift amount against every corner value, and adds random pairs, each compared against arithmetic computed in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    FN_AND   = 4'd0,
    FN_OR    = 4'd1,
    FN_XOR   = 4'd2,
    FN_NOT   = 4'd3,
    FN_ADD   = 4'd4,
    FN_SUB   = 4'd5,
    FN_SHA   = 4'd6,
    FN_SHL   = 4'd7,
    FN_LT    = 4'd8,
    FN_LE    = 4'd9,
    FN_EQ    = 4'd10,
    FN_LTU   = 4'd11,
    FN_LEU   = 4'd12,
    FN_MOV   = 4'd13,
    FN_MOVHI = 4'd14,
    FN_NONE  = 4'd15
  } alu_fn_e;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int WIDTH = 16
) (
  input  logic [1:0]       fn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (fn)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] diff,
  output logic             lt_s,
  output logic             lt_u,
  output logic             eq
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH:0] diff_ext;

  always_comb begin
    sum      = a + b;
    diff_ext = {1'b0, a} - {1'b0, b};
    diff     = diff_ext[MSB:0];
    lt_u     = diff_ext[WIDTH];
    eq       = (diff == '0);
    // operands of opposite sign: the negative one is smaller
    lt_s     = (a[MSB] ^ b[MSB]) ? a[MSB] : lt_u;
  end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit #(
  parameter int WIDTH   = 16,
  parameter int SHAMT_W = 5
) (
  input  logic               arith,
  input  logic [WIDTH-1:0]   a,
  input  logic [SHAMT_W-1:0] amount,
  output logic [WIDTH-1:0]   y
);
  logic               go_right;
  logic [SHAMT_W-1:0] mag_right;
  logic signed [WIDTH-1:0] a_s;

  always_comb begin
    go_right  = amount[SHAMT_W-1];
    mag_right = ~amount + SHAMT_W'(1);
    a_s       = a;
    if (!go_right)
      y = a << amount;
    else if (arith)
      y = a_s >>> mag_right;
    else
      y = a >> mag_right;
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath #(
  parameter int WIDTH   = 16,
  parameter int IMM_W   = 8,
  parameter int SHAMT_W = 5
) (
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [IMM_W-1:0] imm8,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag
);
  import alu_pkg::*;

  localparam int LOW_W = WIDTH - IMM_W;

  alu_fn_e          fn;
  logic [WIDTH-1:0] logic_y, sum_y, diff_y, shift_y;
  logic             lt_s, lt_u, eq;

  assign fn = alu_fn_e'(op_sel);

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .fn (op_sel[1:0]),
    .a  (opnd_a),
    .b  (opnd_b),
    .y  (logic_y)
  );

  alu_arith_unit #(.WIDTH(WIDTH)) u_arith (
    .a    (opnd_a),
    .b    (opnd_b),
    .sum  (sum_y),
    .diff (diff_y),
    .lt_s (lt_s),
    .lt_u (lt_u),
    .eq   (eq)
  );

  alu_shift_unit #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shift (
    .arith  (op_sel[0] == 1'b0),
    .a      (opnd_a),
    .amount (opnd_b[SHAMT_W-1:0]),
    .y      (shift_y)
  );

  function automatic logic [WIDTH-1:0] as_word(input logic bit_in);
    return {{(WIDTH-1){1'b0}}, bit_in};
  endfunction

  always_comb begin
    unique case (fn)
      FN_AND, FN_OR, FN_XOR, FN_NOT: result = logic_y;
      FN_ADD:   result = sum_y;
      FN_SUB:   result = diff_y;
      FN_SHA, FN_SHL: result = shift_y;
      FN_LT:    result = as_word(lt_s);
      FN_LE:    result = as_word(lt_s | eq);
      FN_EQ:    result = as_word(eq);
      FN_LTU:   result = as_word(lt_u);
      FN_LEU:   result = as_word(lt_u | eq);
      FN_MOV:   result = opnd_a;
      FN_MOVHI: result = {imm8, opnd_a[LOW_W-1:0]};
      default:  result = '0;
    endcase
    zero_flag = ~|result;
  end
endmodule

// File: rtl/alu_datapath_checker.sv
module alu_datapath_checker #(
  parameter int WIDTH   = 16,
  parameter int IMM_W   = 8,
  parameter int SHAMT_W = 5
) (
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [IMM_W-1:0] imm8,
  input logic [WIDTH-1:0] result,
  input logic             zero_flag
);
  localparam int LOW_W = WIDTH - IMM_W;
  localparam logic [SHAMT_W-1:0] MOST_NEG = {1'b1, {(SHAMT_W-1){1'b0}}};

  always_comb begin
    // R2
    add_inverse_chk: assert (op_sel != 4'd4 || (result - opnd_b) == opnd_a)
      else $error("add result does not invert");
    // R2
    sub_inverse_chk: assert (op_sel != 4'd5 || (result + opnd_b) == opnd_a)
      else $error("sub result does not invert");
    // R8
    cmp_bool_chk: assert (op_sel < 4'd8 || op_sel > 4'd12 || result[WIDTH-1:1] == '0)
      else $error("compare word not 0/1");
    // R7
    eq_zero_chk: assert (op_sel != 4'd10 || zero_flag == (opnd_a != opnd_b))
      else $error("equality disagrees with zero flag");
    // R9
    mov_pass_chk: assert (op_sel != 4'd13 || result == opnd_a)
      else $error("move altered operand");
    // R10
    movhi_bytes_chk: assert (op_sel != 4'd14 ||
                             (result[WIDTH-1:LOW_W] == imm8 && result[LOW_W-1:0] == opnd_a[LOW_W-1:0]))
      else $error("move-high bytes wrong");
    // R4
    shl_drain_chk: assert (op_sel != 4'd7 || opnd_b[SHAMT_W-1:0] != MOST_NEG || result == '0)
      else $error("logical full right shift not zero");
    // R4
    sha_drain_chk: assert (op_sel != 4'd6 || opnd_b[SHAMT_W-1:0] != MOST_NEG ||
                           result == {WIDTH{opnd_a[WIDTH-1]}})
      else $error("arithmetic full right shift not sign");
    // R12
    unused_code_chk: assert (op_sel != 4'd15 || (result == '0 && zero_flag))
      else $error("unused code not zero");
  end
endmodule

bind alu_datapath alu_datapath_checker #(
  .WIDTH(WIDTH), .IMM_W(IMM_W), .SHAMT_W(SHAMT_W)
) u_chk (
  .op_sel    (op_sel),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .imm8      (imm8),
  .result    (result),
  .zero_flag (zero_flag)
);

// File: tb/tb_alu_datapath.sv
module tb_alu_datapath;
  localparam int CLK_PERIOD = 10;
  localparam int NCORNER = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic [7:0]  imm8 = '0;
  logic [15:0] result;
  logic        zero_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_datapath dut (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm8(imm8),
    .result(result), .zero_flag(zero_flag)
  );

  function automatic logic [15:0] corner(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
      3: return 16'h7FFF;  4: return 16'h8000;  5: return 16'h8001;
      6: return 16'hFFFF;  7: return 16'hFFFE;  8: return 16'h00FF;
      9: return 16'hFF00;  10: return 16'h5A5A; default: return 16'h1234;
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0, 1, 2, 3: return "R1";
      4, 5:       return "R2";
      6, 7:       return "R3/R4";
      8, 9:       return "R5";
      10:         return "R7";
      11, 12:     return "R6";
      13:         return "R9";
      14:         return "R10";
      default:    return "R12";
    endcase
  endfunction

  function automatic logic [15:0] model(input int op, input logic [15:0] a,
                                        input logic [15:0] b, input logic [7:0] im);
    longint ua, ub, sa, sb, n, p, q;
    ua = a; ub = b;
    sa = (ua >= 32768) ? ua - 65536 : ua;
    sb = (ub >= 32768) ? ub - 65536 : ub;
    n  = ub % 32; if (n >= 16) n = n - 32;
    case (op)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return 16'hFFFF - a;
      4: return 16'((ua + ub) % 65536);
      5: return 16'((ua - ub + 65536) % 65536);
      6, 7: begin
        if (n >= 0) return 16'((ua * (64'sd1 << n)) % 65536);
        p = 64'sd1 << (-n);
        if (op == 7) return 16'(ua / p);
        if (sa >= 0) q = sa / p; else q = -((-sa + p - 1) / p);
        return 16'((q + 65536 * 2) % 65536);
      end
      8:  return (sa <  sb) ? 16'd1 : 16'd0;
      9:  return (sa <= sb) ? 16'd1 : 16'd0;
      10: return (ua == ub) ? 16'd1 : 16'd0;
      11: return (ua <  ub) ? 16'd1 : 16'd0;
      12: return (ua <= ub) ? 16'd1 : 16'd0;
      13: return a;
      14: return 16'(im * 256 + (ua % 256));
      default: return 16'd0;
    endcase
  endfunction

  task automatic apply(input int op, input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] im);
    logic [15:0] exp_r;
    @(negedge clk);
    op_sel = 4'(op); opnd_a = a; opnd_b = b; imm8 = im;
    #1;
    exp_r = model(op, a, b, im);
    checks++;
    if (result !== exp_r) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h: result %h expected %h",
               req_of(op), op, a, b, im, result, exp_r);
    end
    checks++;
    if (zero_flag !== (exp_r == 16'd0)) begin
      errors++;
      $display("FAIL R11 op=%0d a=%h b=%h: zero_flag %b expected %b",
               op, a, b, zero_flag, exp_r == 16'd0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R11: idle inputs (AND of zeros) give zero result and flag
    @(negedge clk); #1;
    checks++;
    if (result !== 16'd0 || zero_flag !== 1'b1) begin
      errors++;
      $display("FAIL R11 idle: result %h zero %b expected 0000 1", result, zero_flag);
    end
    // R1 R2 R5 R6 R7 R8 R9 R10 R12: corner cross over every code
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < NCORNER; i++)
        for (int j = 0; j < NCORNER; j++)
          apply(op, corner(i), corner(j), corner(j)[15:8] ^ 8'hA5);
    // R3 R4: every shift amount on every corner, noise in B upper bits
    for (int op = 6; op < 8; op++)
      for (int i = 0; i < NCORNER; i++)
        for (int s = 0; s < 32; s++)
          apply(op, corner(i), {11'($urandom), 5'(s)}, 8'h00);
    // all codes: random pairs
    for (int k = 0; k < 300; k++)
      for (int op = 0; op < 16; op++)
        apply(op, 16'($urandom), 16'($urandom), 8'($urandom));
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule